// File: doc/BRIEF.md
# Timer Counter Channel with Selectable Clock Source

This block is a single timer channel that runs entirely on one master clock and counts edges of a chosen clock source. The source can be one of four internal prescaled clocks or a slow clock input. It can also be one of three external clock inputs. Edges on the chosen source can be counted rising or falling. Counting can be gated by a burst signal taken from one of the external inputs.

Every asynchronous input first passes through a multi-flop synchroniser. Edges are found by comparing successive synchronised samples. The counter therefore advances on at most one master cycle per source edge.

A trigger, from software or from an external event, does not clear the counter at once. It is held pending and takes effect on the next qualified edge. A wrap from the maximum value to zero sets a sticky overflow flag, which a status-read strobe clears. The counter value is driven on a port at all times. A channel enable freezes the count, and while it is low triggers are ignored and any pending trigger is dropped.

Top module: `tcc_channel`

## Requirements
- R1: While reset is asserted, and after it is released, the count output is 0 and the overflow flag is 0.
- R2: With the channel enabled, the counter rises by exactly one on each qualified edge of the selected source and holds otherwise; its value is continuously visible on `cnt_o`.
- R3: `clk_sel_i` picks the source: codes 0, 1, 2 and 3 select internal clocks dividing the master clock by 2, 8, 32 and 128; code 4 selects `slow_clk_i`; codes 5, 6 and 7 select `ext_clk_i[0]`, `ext_clk_i[1]` and `ext_clk_i[2]`.
- R4: When `clk_inv_i` is 1, falling edges of the selected source are counted instead of rising edges.
- R5: `burst_sel_i` code 0 disables gating; codes 1, 2 and 3 gate with `ext_clk_i[0]`, `ext_clk_i[1]` and `ext_clk_i[2]`. A gated edge is counted only while the synchronised gate level is 1.
- R6: An external or slow-clock level change first sampled on master edge m is counted on master edge m+SYNC_STAGES, never earlier.
- R7: A trigger (`sw_trig_i` or `ext_trig_i`) leaves the counter unchanged until the next qualified edge, which loads 0. A trigger in the same cycle as a qualified edge clears the counter on that edge.
- R8: A qualified edge at the all-ones value returns the counter to 0 and sets the overflow flag. A trigger-driven clear at the all-ones value does not set the flag.
- R9: The overflow flag stays set until a cycle with `stat_rd_i` high and no new overflow. An overflow in the same cycle as a read leaves the flag set.
- R10: While `en_i` is 0, edges and triggers do not change the counter, and a trigger pending when `en_i` falls is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable |
| clk_sel_i | input | SEL_W (3) | Count source select |
| clk_inv_i | input | 1 | Count falling edges when 1 |
| burst_sel_i | input | BST_W (2) | Gate select, 0 = no gate |
| ext_clk_i | input | NUM_EXT (3) | Asynchronous external clocks, also gate sources |
| slow_clk_i | input | 1 | Asynchronous slow clock |
| sw_trig_i | input | 1 | Software trigger strobe |
| ext_trig_i | input | 1 | External trigger strobe, synchronous to clk_i |
| stat_rd_i | input | 1 | Status-read strobe, clears the overflow flag |
| cnt_o | output | CNT_W (16) | Live counter value |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The bench builds the channel with a 6-bit counter and keeps the default two-stage synchroniser and the divide ratios of 2 to 128. The narrow counter lets wraps come within a few hundred master cycles. Clears at the all-ones value and a read that coincides with a wrap can then be staged edge by edge. Keeping the default synchroniser depth fixes the count latency of external inputs at two master edges, which the bench checks cycle by cycle.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

   // Action the counter takes on a given master cycle
   typedef enum logic [1:0] {
      ACT_HOLD  = 2'd0,
      ACT_INC   = 2'd1,
      ACT_CLEAR = 2'd2,
      ACT_WRAP  = 2'd3
   } cnt_act_e;

endpackage

// File: rtl/tcc_prescaler.sv
module tcc_prescaler #(
   parameter int NUM_DIV       = 4,
   parameter int DIV_BASE_LOG2 = 1,
   parameter int DIV_STEP_LOG2 = 2
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   output logic [NUM_DIV-1:0] lvl_o,
   output logic [NUM_DIV-1:0] prv_o
);

   localparam int PSC_W = DIV_BASE_LOG2 + (NUM_DIV - 1) * DIV_STEP_LOG2;

   logic [PSC_W-1:0]   psc_q;
   logic [NUM_DIV-1:0] prv_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         psc_q <= '0;
         prv_q <= '0;
      end else begin
         psc_q <= psc_q + 1'b1;
         prv_q <= lvl_o;
      end
   end

   // Each divided clock is one bit of the free-running count
   for (genvar k = 0; k < NUM_DIV; k++) begin : g_tap
      assign lvl_o[k] = psc_q[DIV_BASE_LOG2 - 1 + k * DIV_STEP_LOG2];
   end

   assign prv_o = prv_q;

   // R3
   one_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(lvl_o & ~prv_o));

endmodule

// File: rtl/tcc_sync.sv
module tcc_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] cur_o,
   output logic [WIDTH-1:0] prv_o
);

   logic [WIDTH-1:0] stg_q [STAGES];
   logic [WIDTH-1:0] prv_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
         prv_q <= '0;
      end else begin
         stg_q[0] <= d_i;
         for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
         prv_q <= stg_q[STAGES-1];
      end
   end

   assign cur_o = stg_q[STAGES-1];
   assign prv_o = prv_q;

endmodule

// File: rtl/tcc_edge_sel.sv
module tcc_edge_sel #(
   parameter int NUM_SRC  = 8,
   parameter int NUM_GATE = 3,
   parameter int SEL_W    = 3,
   parameter int BST_W    = 2
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [NUM_SRC-1:0]  lvl_i,
   input  logic [NUM_SRC-1:0]  prv_i,
   input  logic [NUM_GATE-1:0] gate_i,
   input  logic [SEL_W-1:0]    sel_i,
   input  logic                inv_i,
   input  logic [BST_W-1:0]    bst_i,
   output logic                tick_o
);

   logic [NUM_SRC-1:0] rise;
   logic [NUM_SRC-1:0] fall;
   logic               edge_hit;
   logic               gate_ok;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_edge
      assign rise[s] =  lvl_i[s] & ~prv_i[s];
      assign fall[s] = ~lvl_i[s] &  prv_i[s];
   end

   always_comb begin
      edge_hit = 1'b0;
      for (int s = 0; s < NUM_SRC; s++) begin
         if (sel_i == SEL_W'(s)) edge_hit = inv_i ? fall[s] : rise[s];
      end
   end

   always_comb begin
      gate_ok = 1'b1;
      for (int g = 0; g < NUM_GATE; g++) begin
         if (bst_i == BST_W'(g + 1)) gate_ok = gate_i[g];
      end
   end

   assign tick_o = edge_hit & gate_ok;

   for (genvar g = 0; g < NUM_GATE; g++) begin : g_gate_chk
      // R5
      gate_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (bst_i == BST_W'(g + 1) && !gate_i[g]) |-> !tick_o);
   end

endmodule

// File: rtl/tcc_core.sv
module tcc_core
   import tcc_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             tick_i,
   input  logic             sw_trig_i,
   input  logic             ext_trig_i,
   input  logic             stat_rd_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             ovf_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;
   logic             pend_q;
   logic             flag_q;
   logic             trig_any;
   cnt_act_e         act;

   assign trig_any = sw_trig_i | ext_trig_i;

   always_comb begin
      act = ACT_HOLD;
      if (en_i && tick_i) begin
         if (pend_q || trig_any)  act = ACT_CLEAR;
         else if (cnt_q == CNT_MAX) act = ACT_WRAP;
         else                     act = ACT_INC;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         pend_q <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         unique case (act)
            ACT_INC:             cnt_q <= cnt_q + 1'b1;
            ACT_CLEAR, ACT_WRAP: cnt_q <= '0;
            default:             cnt_q <= cnt_q;
         endcase
         if (!en_i || act == ACT_CLEAR) pend_q <= 1'b0;
         else if (trig_any)             pend_q <= 1'b1;
         if (act == ACT_WRAP)    flag_q <= 1'b1;
         else if (stat_rd_i)     flag_q <= 1'b0;
      end
   end

   assign cnt_o = cnt_q;
   assign ovf_o = flag_q;

   // R2
   idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_i |=> $stable(cnt_o));

   // R2
   step_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && tick_i && !pend_q && !trig_any && cnt_o != CNT_MAX)
      |=> cnt_o == $past(cnt_o) + 1'b1);

   // R7
   trig_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && tick_i && (pend_q || trig_any)) |=> cnt_o == '0);

   // R8
   wrap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ovf_o) |-> cnt_o == '0);

   // R9
   sticky_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovf_o && !stat_rd_i) |=> ovf_o);

   // R10
   disabled_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> ($stable(cnt_o) && !pend_q));

endmodule

// File: rtl/tcc_channel.sv
module tcc_channel #(
   parameter int CNT_W         = 16,
   parameter int NUM_DIV       = 4,
   parameter int DIV_BASE_LOG2 = 1,
   parameter int DIV_STEP_LOG2 = 2,
   parameter int NUM_EXT       = 3,
   parameter int SYNC_STAGES   = 2,
   localparam int NUM_SRC      = NUM_DIV + 1 + NUM_EXT,
   localparam int SEL_W        = $clog2(NUM_SRC),
   localparam int BST_W        = $clog2(NUM_EXT + 1)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               en_i,
   input  logic [SEL_W-1:0]   clk_sel_i,
   input  logic               clk_inv_i,
   input  logic [BST_W-1:0]   burst_sel_i,
   input  logic [NUM_EXT-1:0] ext_clk_i,
   input  logic               slow_clk_i,
   input  logic               sw_trig_i,
   input  logic               ext_trig_i,
   input  logic               stat_rd_i,
   output logic [CNT_W-1:0]   cnt_o,
   output logic               ovf_o
);

   // Elaboration-time parameter checks
   if (CNT_W < 2) begin : g_bad_cnt_w
      $error("tcc_channel: CNT_W must be at least 2");
   end
   if (NUM_DIV < 1 || DIV_BASE_LOG2 < 1 || DIV_STEP_LOG2 < 1) begin : g_bad_div
      $error("tcc_channel: divider parameters must be at least 1");
   end
   if (NUM_EXT < 1) begin : g_bad_ext
      $error("tcc_channel: NUM_EXT must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("tcc_channel: SYNC_STAGES must be at least 2");
   end

   logic [NUM_DIV-1:0] psc_lvl;
   logic [NUM_DIV-1:0] psc_prv;
   logic [NUM_EXT:0]   asy_cur;
   logic [NUM_EXT:0]   asy_prv;
   logic [NUM_SRC-1:0] src_lvl;
   logic [NUM_SRC-1:0] src_prv;
   logic               tick;

   tcc_prescaler #(
      .NUM_DIV       (NUM_DIV),
      .DIV_BASE_LOG2 (DIV_BASE_LOG2),
      .DIV_STEP_LOG2 (DIV_STEP_LOG2)
   ) u_psc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_o  (psc_lvl),
      .prv_o  (psc_prv)
   );

   // Bit 0 carries the slow clock, bits above carry the external clocks
   tcc_sync #(
      .WIDTH  (NUM_EXT + 1),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    ({ext_clk_i, slow_clk_i}),
      .cur_o  (asy_cur),
      .prv_o  (asy_prv)
   );

   assign src_lvl = {asy_cur, psc_lvl};
   assign src_prv = {asy_prv, psc_prv};

   tcc_edge_sel #(
      .NUM_SRC  (NUM_SRC),
      .NUM_GATE (NUM_EXT),
      .SEL_W    (SEL_W),
      .BST_W    (BST_W)
   ) u_sel (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (src_lvl),
      .prv_i  (src_prv),
      .gate_i (asy_cur[NUM_EXT:1]),
      .sel_i  (clk_sel_i),
      .inv_i  (clk_inv_i),
      .bst_i  (burst_sel_i),
      .tick_o (tick)
   );

   tcc_core #(
      .CNT_W (CNT_W)
   ) u_core (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (en_i),
      .tick_i     (tick),
      .sw_trig_i  (sw_trig_i),
      .ext_trig_i (ext_trig_i),
      .stat_rd_i  (stat_rd_i),
      .cnt_o      (cnt_o),
      .ovf_o      (ovf_o)
   );

endmodule

// File: tb/tcc_channel_tb_top.sv
`timescale 1ns/1ps
module tcc_channel_tb_top;

   localparam int CNT_W   = 6;
   localparam int NUM_DIV = 4;
   localparam int BASE_L2 = 1;
   localparam int STEP_L2 = 2;
   localparam int NUM_EXT = 3;
   localparam int SYNC    = 2;
   localparam int MODV    = 1 << CNT_W;
   localparam int MAXV    = MODV - 1;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               en = 1'b0;
   logic [2:0]         sel = '0;
   logic               inv = 1'b0;
   logic [1:0]         bst = '0;
   logic [NUM_EXT-1:0] ext = '0;
   logic               slow = 1'b0;
   logic               sw_trig = 1'b0;
   logic               ex_trig = 1'b0;
   logic               rd = 1'b0;
   logic [CNT_W-1:0]   cnt;
   logic               ovf;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #5 clk = ~clk;

   tcc_channel #(
      .CNT_W (CNT_W), .NUM_DIV (NUM_DIV), .DIV_BASE_LOG2 (BASE_L2),
      .DIV_STEP_LOG2 (STEP_L2), .NUM_EXT (NUM_EXT), .SYNC_STAGES (SYNC)
   ) dut_i (
      .clk_i (clk), .rst_ni (rst_n), .en_i (en), .clk_sel_i (sel),
      .clk_inv_i (inv), .burst_sel_i (bst), .ext_clk_i (ext),
      .slow_clk_i (slow), .sw_trig_i (sw_trig), .ext_trig_i (ex_trig),
      .stat_rd_i (rd), .cnt_o (cnt), .ovf_o (ovf)
   );

   // Behavioural reference model
   int               m_cnt = 0;
   bit               m_pend = 0;
   bit               m_flag = 0;
   int               n_edge = 0;
   logic [NUM_EXT:0] hist [$];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 0; m_pend = 0; m_flag = 0; n_edge = 0;
         hist.delete();
         for (int i = 0; i <= SYNC; i++) hist.push_back('0);
      end else begin
         int               s, b, cv, pv;
         bit               l, p, hit, gate, trg;
         logic [NUM_EXT:0] cur, prv;
         cur = hist[SYNC-1];
         prv = hist[SYNC];
         s = int'(sel);
         if (s < NUM_DIV) begin
            b  = BASE_L2 - 1 + s * STEP_L2;
            cv = n_edge;
            pv = (n_edge > 0) ? n_edge - 1 : 0;
            l  = ((cv >> b) & 1) == 1;
            p  = ((pv >> b) & 1) == 1;
         end else begin
            l = cur[s - NUM_DIV];
            p = prv[s - NUM_DIV];
         end
         hit  = inv ? (!l && p) : (l && !p);
         gate = (bst == 0) ? 1'b1 : cur[bst];
         trg  = sw_trig || ex_trig;
         if (!en) begin
            m_pend = 0;
            if (rd) m_flag = 0;
         end else if (hit && gate) begin
            if (m_pend || trg) begin
               m_cnt = 0; m_pend = 0;
               if (rd) m_flag = 0;
            end else if (m_cnt == MAXV) begin
               m_cnt = 0; m_flag = 1;
            end else begin
               m_cnt++;
               if (rd) m_flag = 0;
            end
         end else begin
            if (trg) m_pend = 1;
            if (rd) m_flag = 0;
         end
         hist.push_front({ext, slow});
         void'(hist.pop_back());
         n_edge++;
      end
   end

   task automatic check(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Compare against the model on every cycle
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R2 count vs model", int'(cnt), m_cnt);
         check("R9 flag vs model", int'(ovf), int'(m_flag));
      end
   end

   task automatic pulse_ext(int ch);
      ext[ch] = 1'b1;
      repeat (3) @(negedge clk);
      ext[ch] = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_fail++;
         $display("FAIL R2 watchdog: actual %0d expected %0d", 0, 1);
         summary();
         $finish;
      end
   end

   initial begin
      int c0, n;
      repeat (3) @(negedge clk);
      check("R1 count in reset", int'(cnt), 0);
      check("R1 flag in reset", int'(ovf), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 count after reset", int'(cnt), 0);
      check("R1 flag after reset", int'(ovf), 0);
      en = 1'b1;

      // R3 internal dividers
      for (int s = 0; s < NUM_DIV; s++) begin
         sel = 3'(s);
         repeat (300) @(negedge clk);
         check("R3 internal divider", int'(cnt), m_cnt);
      end

      // R3 external and slow sources
      sel = 3'd5; inv = 1'b0;
      c0 = int'(cnt);
      for (int i = 0; i < 10; i++) pulse_ext(0);
      check("R3 ext0 source", int'(cnt), (c0 + 10) % MODV);
      sel = 3'd7;
      c0 = int'(cnt);
      for (int i = 0; i < 4; i++) pulse_ext(2);
      check("R3 ext2 source", int'(cnt), (c0 + 4) % MODV);
      sel = 3'd4;
      c0 = int'(cnt);
      for (int i = 0; i < 4; i++) begin
         slow = 1'b1; repeat (4) @(negedge clk);
         slow = 1'b0; repeat (4) @(negedge clk);
      end
      check("R3 slow source", int'(cnt), (c0 + 4) % MODV);

      // R4 inverted edge
      sel = 3'd6; inv = 1'b1;
      c0 = int'(cnt);
      ext[1] = 1'b1; repeat (4) @(negedge clk);
      check("R4 rising edge ignored", int'(cnt), c0);
      ext[1] = 1'b0; repeat (4) @(negedge clk);
      check("R4 falling edge counted", int'(cnt), (c0 + 1) % MODV);
      inv = 1'b0;

      // R5 burst gating by ext1
      sel = 3'd5; bst = 2'd2;
      c0 = int'(cnt);
      for (int i = 0; i < 5; i++) pulse_ext(0);
      check("R5 gate low blocks", int'(cnt), c0);
      ext[1] = 1'b1; repeat (4) @(negedge clk);
      for (int i = 0; i < 5; i++) pulse_ext(0);
      check("R5 gate high passes", int'(cnt), (c0 + 5) % MODV);
      ext[1] = 1'b0; repeat (4) @(negedge clk);
      bst = 2'd0;

      // R6 synchroniser latency
      c0 = int'(cnt);
      ext[0] = 1'b1;
      for (int i = 0; i < SYNC; i++) begin
         @(negedge clk);
         check("R6 not yet counted", int'(cnt), c0);
      end
      @(negedge clk);
      check("R6 counted after sync", int'(cnt), (c0 + 1) % MODV);
      ext[0] = 1'b0; repeat (3) @(negedge clk);

      // R7 pending trigger
      if (int'(cnt) == 0) pulse_ext(0);
      c0 = int'(cnt);
      sw_trig = 1'b1; @(negedge clk); sw_trig = 1'b0;
      repeat (6) @(negedge clk);
      check("R7 trigger waits", int'(cnt), c0);
      pulse_ext(0);
      check("R7 cleared on edge", int'(cnt), 0);
      pulse_ext(0); pulse_ext(0);
      ex_trig = 1'b1; @(negedge clk); ex_trig = 1'b0;
      repeat (4) @(negedge clk);
      check("R7 ext trigger waits", int'(cnt), 2);
      pulse_ext(0);
      check("R7 ext trigger clears", int'(cnt), 0);
      pulse_ext(0);
      ext[0] = 1'b1;
      @(negedge clk);
      repeat (SYNC - 1) @(negedge clk);
      sw_trig = 1'b1; @(negedge clk); sw_trig = 1'b0;
      check("R7 coincident trigger", int'(cnt), 0);
      ext[0] = 1'b0; repeat (3) @(negedge clk);
      pulse_ext(0);
      check("R7 no leftover pending", int'(cnt), 1);

      // R10 disable
      c0 = int'(cnt);
      en = 1'b0;
      sw_trig = 1'b1; @(negedge clk); sw_trig = 1'b0;
      for (int i = 0; i < 3; i++) pulse_ext(0);
      check("R10 frozen while disabled", int'(cnt), c0);
      en = 1'b1;
      sw_trig = 1'b1; @(negedge clk); sw_trig = 1'b0;
      en = 1'b0; @(negedge clk); en = 1'b1;
      pulse_ext(0);
      check("R10 pending discarded", int'(cnt), (c0 + 1) % MODV);

      // R8 trigger clear at max
      rd = 1'b1; @(negedge clk); rd = 1'b0;
      check("R9 read clears", int'(ovf), 0);
      n = (MAXV - int'(cnt)) % MODV;
      for (int i = 0; i < n; i++) pulse_ext(0);
      check("R2 reached max", int'(cnt), MAXV);
      sw_trig = 1'b1; @(negedge clk); sw_trig = 1'b0;
      pulse_ext(0);
      check("R8 trigger clear value", int'(cnt), 0);
      check("R8 trigger clear no flag", int'(ovf), 0);
      for (int i = 0; i < MODV; i++) pulse_ext(0);
      check("R8 wrap value", int'(cnt), 0);
      check("R8 wrap sets flag", int'(ovf), 1);
      repeat (5) @(negedge clk);
      check("R9 flag sticky", int'(ovf), 1);
      rd = 1'b1; @(negedge clk); rd = 1'b0;
      check("R9 flag cleared", int'(ovf), 0);

      // R9 read coinciding with wrap
      for (int i = 0; i < MAXV; i++) pulse_ext(0);
      ext[0] = 1'b1;
      @(negedge clk);
      repeat (SYNC - 1) @(negedge clk);
      rd = 1'b1; @(negedge clk); rd = 1'b0;
      check("R9 wrap beats read", int'(ovf), 1);
      check("R8 wrap on coincident read", int'(cnt), 0);
      ext[0] = 1'b0; repeat (3) @(negedge clk);

      // R9 continuous reads while counting fast
      sel = 3'd0; rd = 1'b1;
      repeat (300) @(negedge clk);
      rd = 1'b0; @(negedge clk);
      check("R9 flag under reads", int'(ovf), int'(m_flag));

      done = 1;
      summary();
      $finish;
   end

endmodule